// File: doc/BRIEF.md
# SPI Command-Queue Transfer Controller

This block sequences the transfers of an SPI master from a queue of command entries. Each entry that a DMA-style producer writes into the transmit FIFO pairs a data word with two command bits. One bit marks the last entry of a queue. The other resets the transfer counter. While the engine runs, it pops one entry at a time and hands the word to an external shift engine over a request/acknowledge handshake. It stores the returned word in a receive FIFO and counts the completed frame.

When the frame of a queue-ending entry completes, the block raises a sticky end-of-queue flag and stops launching frames. Software then drains the receive FIFO through a pop address on a small register port. It flushes either FIFO if required, clears the flag, and the next queue starts. A disable mode freezes the software-visible state: flushes, counter writes and flag clears are ignored, while reads still return live values.

Top module: `spiq_ctrl`

## Requirements
- R1: After reset, no frame is requested. The control word (address 0) and the transfer counter (address 2) read 0. In the status word (address 1), bit 0 end-of-queue, bit 1 running, bit 2 receive-not-empty, bit 3 transmit-full, bits 10:8 receive count and bits 18:16 transmit count all read 0.
- R2: Entries are sent in push order. `xfer_req` stays high with `xfer_tx` stable until the cycle in which `xfer_ack` is sampled high.
- R3: When the frame of an entry pushed with `txq_eoq=1` completes, status bit 0 and `irq_eoq` go to 1 and status bit 1 goes to 0. No further frame is launched while the flag is set.
- R4: The transfer counter (address 2) increments by one for each completed frame.
- R5: Each returned word is stored in the receive FIFO in order. Status bits 10:8 give its occupancy and `rx_dreq` is high while it is non-empty. A read strobe at address 3 returns the oldest word in `reg_rdata` and removes it.
- R6: While the engine is stopped, the transmit FIFO accepts pushes up to DEPTH entries. `txq_full` and status bit 3 are then high, and further pushes are dropped.
- R7: A control write (address 0) with bit 2 set empties the transmit FIFO. A control write with bit 3 set empties the receive FIFO.
- R8: The counter is zeroed before an entry pushed with `txq_ctc=1` is counted, so it reads 1 after that frame. A write to address 2 loads the counter directly.
- R9: While control bit 0 (disable) is 1, the following have no effect: flush bits, counter writes, and write-1-to-clear of status bit 0. `irq_eoq` therefore stays high. The engine is stopped.
- R10: If a transmit flush and a push land in the same cycle, the flush wins and the pushed entry is discarded.
- R11: With disable at 0 and control bit 1 (go) at 1, writing 1 to status bit 0 clears the flag and status bit 1 returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| txq_push | input | 1 | Push one entry into the transmit FIFO |
| txq_data | input | DW | Entry data word |
| txq_eoq | input | 1 | Entry end-of-queue command bit |
| txq_ctc | input | 1 | Entry clear-counter command bit |
| txq_full | output | 1 | Transmit FIFO full |
| xfer_req | output | 1 | Frame request to the shift engine |
| xfer_tx | output | DW | Word to shift out |
| xfer_ack | input | 1 | Frame done, one cycle |
| xfer_rx | input | DW | Word shifted in, valid with `xfer_ack` |
| irq_eoq | output | 1 | End-of-queue interrupt level |
| rx_dreq | output | 1 | Receive data request level |

## Verification
A pushed entry is poppable one edge after its push. A running engine raises `xfer_req` one edge later. Status, counter and receive FIFO update on the edge that samples `xfer_ack`, and register writes show in the next read. The bench drives on the falling edge and samples on the next falling edge after the effect is due, so every comparison lands on a settled cycle. Frame-completion checks wait a fixed margin much longer than the slave model's three-cycle acknowledge delay. The scoreboard compares each word at the moment of its acknowledge.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
   // register map
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_TCNT = 2'd2;
   localparam logic [1:0] A_POP  = 2'd3;
   // control bits
   localparam int C_DIS   = 0;
   localparam int C_GO    = 1;
   localparam int C_CLRTX = 2;
   localparam int C_CLRRX = 3;
   // status bits
   localparam int S_EOQ    = 0;
   localparam int S_RUN    = 1;
   localparam int S_RXNE   = 2;
   localparam int S_TXFULL = 3;
   localparam int S_RXCNT  = 8;
   localparam int S_TXCNT  = 16;

   typedef struct packed {
      logic eoq;
      logic ctc;
   } cmd_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
   parameter int W     = 18,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty
);
   localparam bit POW2 = (DEPTH == (1 << PW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("spiq_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spiq_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign cnt     = cnt_q;
   assign dout    = mem[rp];
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      logic [PW-1:0] r;
      if (POW2) r = p + 1'b1;
      else      r = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R7
   AST_FLUSH_BEATS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush && push |=> cnt == '0); // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full && cnt == CW'(DEPTH)); // R6
endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
   import spiq_pkg::*;
#(
   parameter int DW  = 16,
   parameter int TCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic           mod_dis,
   input  logic           tx_empty,
   input  logic           rx_full,
   input  logic [DW-1:0]  ent_data,
   input  cmd_t           ent_cmd,
   input  logic           xfer_ack,
   input  logic           cnt_wr,
   input  logic [TCW-1:0] cnt_wdata,
   input  logic           eoq_clr,
   output logic           tx_pop,
   output logic           rx_push,
   output logic           xfer_req,
   output logic [DW-1:0]  xfer_tx,
   output logic           eoq_flag,
   output logic           running,
   output logic [TCW-1:0] tcnt
);
   if (TCW < 2 || TCW > 32) begin : g_bad_tcw
      $error("spiq_seq: TCW must lie in 2..32");
   end

   logic           busy;
   logic [DW-1:0]  hold_data;
   cmd_t           hold_cmd;
   logic           eoq_q;
   logic [TCW-1:0] tcnt_q;
   logic           launch, done;

   assign running  = go && !eoq_q && !mod_dis;
   assign launch   = running && !busy && !tx_empty && !rx_full;
   assign done     = busy && xfer_ack;
   assign tx_pop   = launch;
   assign rx_push  = done;
   assign xfer_req = busy;
   assign xfer_tx  = hold_data;
   assign eoq_flag = eoq_q;
   assign tcnt     = tcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         hold_data <= '0;
         hold_cmd  <= '0;
         eoq_q     <= 1'b0;
         tcnt_q    <= '0;
      end else begin
         if (launch) begin
            busy      <= 1'b1;
            hold_data <= ent_data;
            hold_cmd  <= ent_cmd;
         end else if (done) begin
            busy <= 1'b0;
         end

         if (done && hold_cmd.eoq)      eoq_q <= 1'b1;
         else if (eoq_clr && !mod_dis)  eoq_q <= 1'b0;

         if (done)                      tcnt_q <= (hold_cmd.ctc ? '0 : tcnt_q) + TCW'(1);
         else if (cnt_wr && !mod_dis)   tcnt_q <= cnt_wdata;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx)); // R2
   AST_EOQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      done && hold_cmd.eoq |=> eoq_flag && !running); // R3
   AST_NO_LAUNCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !xfer_req |=> !xfer_req); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      done && !hold_cmd.ctc |=> tcnt == TCW'($past(tcnt) + TCW'(1))); // R4
   AST_CTC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done && hold_cmd.ctc |=> tcnt == TCW'(1)); // R8
   AST_DIS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      mod_dis && !done |=> $stable(tcnt)); // R9
   AST_DIS_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mod_dis && eoq_flag |=> eoq_flag); // R9
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
   import spiq_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   parameter int TCW   = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          txq_push,
   input  logic [DW-1:0] txq_data,
   input  logic          txq_eoq,
   input  logic          txq_ctc,
   output logic          txq_full,
   output logic          xfer_req,
   output logic [DW-1:0] xfer_tx,
   input  logic          xfer_ack,
   input  logic [DW-1:0] xfer_rx,
   output logic          irq_eoq,
   output logic          rx_dreq
);
   localparam int EW = DW + $bits(cmd_t);
   localparam int CW = $clog2(DEPTH + 1);

   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("spiq_ctrl: DW must lie in 1..32");
   end
   if (CW > 8) begin : g_bad_depth
      $error("spiq_ctrl: DEPTH too large for the status count fields");
   end

   logic dis_q, go_q;
   logic wr_ctrl, wr_stat, wr_tcnt, rd_pop;
   logic flush_tx, flush_rx;

   logic [EW-1:0] tx_dout;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_full, tx_empty, tx_pop;
   logic [DW-1:0] rx_dout;
   logic          rx_full, rx_empty, rx_push;
   logic          eoq_flag, running;
   logic [TCW-1:0] tcnt;
   cmd_t          push_cmd, ent_cmd;
   logic          unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_stat  = reg_wr && (reg_addr == A_STAT);
   assign wr_tcnt  = reg_wr && (reg_addr == A_TCNT);
   assign rd_pop   = reg_rd && (reg_addr == A_POP);
   assign flush_tx = wr_ctrl && reg_wdata[C_CLRTX] && !dis_q;
   assign flush_rx = wr_ctrl && reg_wdata[C_CLRRX] && !dis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= 1'b0;
         go_q  <= 1'b0;
      end else if (wr_ctrl) begin
         dis_q <= reg_wdata[C_DIS];
         go_q  <= reg_wdata[C_GO];
      end
   end

   assign push_cmd = '{eoq: txq_eoq, ctc: txq_ctc};

   spiq_fifo #(.W(EW), .DEPTH(DEPTH)) u_txf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_tx),
      .push  (txq_push),
      .din   ({push_cmd, txq_data}),
      .pop   (tx_pop),
      .dout  (tx_dout),
      .cnt   (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spiq_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_rx),
      .push  (rx_push),
      .din   (xfer_rx),
      .pop   (rd_pop),
      .dout  (rx_dout),
      .cnt   (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign ent_cmd = cmd_t'(tx_dout[EW-1:DW]);

   spiq_seq #(.DW(DW), .TCW(TCW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go_q),
      .mod_dis   (dis_q),
      .tx_empty  (tx_empty),
      .rx_full   (rx_full),
      .ent_data  (tx_dout[DW-1:0]),
      .ent_cmd   (ent_cmd),
      .xfer_ack  (xfer_ack),
      .cnt_wr    (wr_tcnt),
      .cnt_wdata (reg_wdata[TCW-1:0]),
      .eoq_clr   (wr_stat && reg_wdata[S_EOQ]),
      .tx_pop    (tx_pop),
      .rx_push   (rx_push),
      .xfer_req  (xfer_req),
      .xfer_tx   (xfer_tx),
      .eoq_flag  (eoq_flag),
      .running   (running),
      .tcnt      (tcnt)
   );

   assign txq_full = tx_full;
   assign irq_eoq  = eoq_flag;
   assign rx_dreq  = !rx_empty;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_DIS] = dis_q;
            reg_rdata[C_GO]  = go_q;
         end
         A_STAT: begin
            reg_rdata[S_EOQ]           = eoq_flag;
            reg_rdata[S_RUN]           = running;
            reg_rdata[S_RXNE]          = !rx_empty;
            reg_rdata[S_TXFULL]        = tx_full;
            reg_rdata[S_RXCNT +: CW]   = rx_cnt;
            reg_rdata[S_TXCNT +: CW]   = tx_cnt;
         end
         A_TCNT:  reg_rdata[TCW-1:0] = tcnt;
         default: reg_rdata[DW-1:0]  = rx_dout;
      endcase
   end

   AST_DREQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && !flush_rx |=> rx_dreq); // R5
   AST_DIS_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q && !txq_push && !tx_pop |=> $stable(tx_cnt)); // R9
endmodule

// File: tb/tb_spiq_ctrl.sv
`timescale 1ns/1ps
module tb_spiq_ctrl;
   localparam int DW = 16;
   localparam int DEPTH = 4;
   localparam int TCW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          txq_push = 1'b0, txq_eoq = 1'b0, txq_ctc = 1'b0;
   logic [DW-1:0] txq_data = '0;
   logic          txq_full, xfer_req, irq_eoq, rx_dreq;
   logic [DW-1:0] xfer_tx;
   logic          xfer_ack = 1'b0;
   logic [DW-1:0] xfer_rx = '0;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_tx[$];
   logic [DW-1:0] exp_rx[$];

   always #2.5 clk = ~clk;

   spiq_ctrl #(.DW(DW), .DEPTH(DEPTH), .TCW(TCW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .txq_push(txq_push), .txq_data(txq_data), .txq_eoq(txq_eoq),
      .txq_ctc(txq_ctc), .txq_full(txq_full), .xfer_req(xfer_req),
      .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .irq_eoq(irq_eoq), .rx_dreq(rx_dreq)
   );

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pop_check(input string r);
      logic [DW-1:0] e;
      @(negedge clk);
      reg_addr = 2'd3; reg_rd = 1'b1;
      #1;
      e = (exp_rx.size() != 0) ? exp_rx.pop_front() : '0;
      check(r, {16'h0, reg_rdata[DW-1:0]}, {16'h0, e});
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // driver: expected words go to the scoreboard only when a frame is due
   task automatic push(input logic [DW-1:0] d, input logic eoq, input logic ctc, input bit due);
      @(negedge clk);
      txq_push = 1'b1; txq_data = d; txq_eoq = eoq; txq_ctc = ctc;
      if (due) exp_tx.push_back(d);
      @(negedge clk);
      txq_push = 1'b0; txq_eoq = 1'b0; txq_ctc = 1'b0;
   endtask

   // shift-engine model and monitor
   initial begin
      forever begin
         @(negedge clk);
         if (xfer_req) begin
            repeat (2) @(negedge clk);
            if (exp_tx.size() == 0) begin
               check("R2 unexpected frame", {16'h0, xfer_tx}, 32'hFFFF_FFFF);
            end else begin
               check("R2 frame word order", {16'h0, xfer_tx}, {16'h0, exp_tx.pop_front()});
            end
            xfer_rx = xfer_tx ^ 16'h5A5A;
            exp_rx.push_back(xfer_tx ^ 16'h5A5A);
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd1, v); check("R1 status", v, 32'h0);
      rd(2'd0, v); check("R1 control", v, 32'h0);
      rd(2'd2, v); check("R1 counter", v, 32'h0);
      check("R1 no request", {31'h0, xfer_req}, 32'h0);

      // R2/R3/R4/R5: one queue of three entries
      wr(2'd0, 32'h2);
      push(16'h1111, 1'b0, 1'b0, 1'b1);
      push(16'h2222, 1'b0, 1'b0, 1'b1);
      push(16'h3333, 1'b1, 1'b0, 1'b1);
      repeat (40) @(negedge clk);
      rd(2'd1, v);
      check("R3 eoq flag", {31'h0, v[0]}, 32'h1);
      check("R3 running cleared", {31'h0, v[1]}, 32'h0);
      check("R3 irq_eoq", {31'h0, irq_eoq}, 32'h1);
      check("R5 rx count", {29'h0, v[10:8]}, 32'h3);
      check("R5 rx_dreq", {31'h0, rx_dreq}, 32'h1);
      rd(2'd2, v); check("R4 counter", v, 32'h3);
      pop_check("R5 pop word 1");
      pop_check("R5 pop word 2");
      pop_check("R5 pop word 3");
      rd(2'd1, v); check("R5 rx drained", {29'h0, v[10:8]}, 32'h0);

      // R6 fill while stopped
      for (int i = 0; i < DEPTH + 1; i++) push(16'hA000 + 16'(i), 1'b0, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      check("R6 no frame while stopped", {31'h0, xfer_req}, 32'h0);
      rd(2'd1, v);
      check("R6 tx count", {29'h0, v[18:16]}, DEPTH);
      check("R6 tx full", {31'h0, txq_full}, 32'h1);

      // R7 transmit flush
      wr(2'd0, 32'h6);
      rd(2'd1, v); check("R7 tx flushed", {29'h0, v[18:16]}, 32'h0);

      // R8 direct counter load
      wr(2'd2, 32'h9);
      rd(2'd2, v); check("R8 counter write", v, 32'h9);

      // R11 restart
      wr(2'd1, 32'h1);
      rd(2'd1, v);
      check("R11 flag cleared", {31'h0, v[0]}, 32'h0);
      check("R11 running again", {31'h0, v[1]}, 32'h1);

      // R8 clear-count entry
      push(16'h4444, 1'b1, 1'b1, 1'b1);
      repeat (20) @(negedge clk);
      rd(2'd2, v); check("R8 clear-count frame", v, 32'h1);

      // R7 receive flush
      wr(2'd0, 32'hA);
      exp_rx.delete();
      rd(2'd1, v); check("R7 rx flushed", {29'h0, v[10:8]}, 32'h0);
      check("R7 rx_dreq low", {31'h0, rx_dreq}, 32'h0);

      // R9 disable mode
      wr(2'd0, 32'h3);
      push(16'h5555, 1'b0, 1'b0, 1'b0);
      wr(2'd2, 32'h0);
      wr(2'd0, 32'h7);
      wr(2'd1, 32'h1);
      repeat (5) @(negedge clk);
      rd(2'd2, v); check("R9 counter frozen", v, 32'h1);
      rd(2'd1, v);
      check("R9 flush ignored", {29'h0, v[18:16]}, 32'h1);
      check("R9 flag kept", {31'h0, v[0]}, 32'h1);
      check("R9 irq held", {31'h0, irq_eoq}, 32'h1);
      check("R9 stopped", {31'h0, v[1]}, 32'h0);

      // R10 flush beats a same-cycle push
      wr(2'd0, 32'h2);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h6;
      txq_push = 1'b1; txq_data = 16'h6666;
      @(negedge clk);
      reg_wr = 1'b0; txq_push = 1'b0;
      rd(2'd1, v); check("R10 flush wins", {29'h0, v[18:16]}, 32'h0);

      check("R2 scoreboard drained", exp_tx.size(), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule